// File: doc/BRIEF.md
# Memory Carveout Access Filter

The filter sits in front of a DRAM port and judges every incoming request against two programmable protected windows. The first, the secure window, admits only requests flagged secure. The second, the media window, refuses any request from a CPU-class requestor. Every request is answered with a grant or a fault. A refused request also sets a sticky cause bit, and its address is captured for software to read.

Both windows are set up through a small 32-bit configuration port. Each window has a 40-bit byte base, written as a low word and a high word, and a size counted in whole MiB. A size of zero switches the window off. Requests arrive on a valid/ready channel. Verdicts leave on a second valid/ready channel one cycle after the request is accepted.

Back-pressure works as follows. The output register holds a single verdict. The filter accepts a new request only when that register is empty, or when the register's verdict is being taken in the same cycle. While a verdict waits for `rsp_ready`, it does not change.

Top module: `carveout_filter`

## Requirements
- R1: After reset, every configuration register, the cause bits and `fault_irq` are zero and `rsp_valid` is low. Both windows are therefore off, and every request is granted.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. Its verdict appears on `rsp_valid`/`rsp_fault` one cycle later. `req_ready` equals `!rsp_valid || rsp_ready`. A verdict holds its value until it is taken.
- R3: An address hits the secure window when base <= addr < base + size*2^20. A non-secure request (`req_secure`=0) that hits gets a fault. A secure request that hits is granted.
- R4: An address hits the media window under the same rule. A request with `req_cpu`=1 that hits gets a fault whatever its secure flag. A request with `req_cpu`=0 that hits is granted.
- R5: A window whose size register is zero matches no address.
- R6: The upper bound is exclusive and is computed one bit wider than the address. The address at the base hits, the address at end-1 hits, and the addresses at end and at base-1 miss. A window whose end is exactly 2^40 still matches its top byte.
- R7: An address inside the secure window is judged by the secure rule alone, even when the media window also covers it. A secure CPU request there is granted, and a non-secure CPU request there sets only the secure cause bit.
- R8: The cause register (index 6) has bit 0 for secure faults and bit 1 for media faults. Its bits are sticky. Writing 1 to a bit clears it, and writing 0 leaves it unchanged. `fault_irq` is high while any cause bit is set.
- R9: Every faulting acceptance stores its address. Index 7 reads bits 31:0 of the address and index 8 reads bits 39:32 in bits 7:0.
- R10: The register indices are: 0 secure base low, 1 secure base high, 2 secure size in MiB, 3 media base low, 4 media base high, 5 media size in MiB. The high-base registers keep bits 7:0 only, the size registers keep bits 19:0, and bits that are not kept read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration register index (read and write) |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data (combinational on cfg_addr) |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request ready |
| req_addr | input | 40 | Request byte address |
| req_secure | input | 1 | Request is secure |
| req_cpu | input | 1 | Request comes from a CPU-class requestor |
| rsp_valid | output | 1 | Verdict valid |
| rsp_ready | input | 1 | Verdict taken by the downstream side |
| rsp_fault | output | 1 | 1 = refused, 0 = granted |
| fault_irq | output | 1 | Any cause bit set |

## Verification
The embedded properties watch the channel rules on every cycle:
- `req_ready` stays low while a verdict is stalled.
- A stalled verdict holds its value.
- Every acceptance produces a verdict on the next cycle.
- Cause bits stay set until a 1 is written to them.
- A written 1 clears a bit when no new fault arrives in the same cycle.

The bench scenarios show what the properties cannot:
- the window boundaries, including the end at 2^40;
- the priority of the secure window where the two windows overlap;
- zero-size windows;
- captured fault addresses;
- the register readback widths.

// File: rtl/carveout_pkg.sv
package carveout_pkg;
  localparam logic [3:0] IDX_SEC_LO  = 4'd0;
  localparam logic [3:0] IDX_SEC_HI  = 4'd1;
  localparam logic [3:0] IDX_SEC_SZ  = 4'd2;
  localparam logic [3:0] IDX_VID_LO  = 4'd3;
  localparam logic [3:0] IDX_VID_HI  = 4'd4;
  localparam logic [3:0] IDX_VID_SZ  = 4'd5;
  localparam logic [3:0] IDX_CAUSE   = 4'd6;
  localparam logic [3:0] IDX_FADDR_L = 4'd7;
  localparam logic [3:0] IDX_FADDR_H = 4'd8;

  localparam int CAUSE_SEC = 0;
  localparam int CAUSE_VID = 1;
  localparam int N_CAUSE   = 2;
endpackage

// File: rtl/carveout_window.sv
module carveout_window #(
  parameter int ADDR_W   = 40,
  parameter int MB_SHIFT = 20,
  localparam int SIZE_W  = ADDR_W - MB_SHIFT
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [SIZE_W-1:0] size_mb,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  // One extra bit keeps base + span from wrapping at the top of the map.
  logic [ADDR_W:0] limit;
  logic [ADDR_W:0] span;

  always_comb begin
    span  = {1'b0, size_mb, {MB_SHIFT{1'b0}}};
    limit = {1'b0, base} + span;
    hit   = (size_mb != '0) && (addr >= base) && ({1'b0, addr} < limit);
  end
endmodule

// File: rtl/carveout_regs.sv
module carveout_regs
  import carveout_pkg::*;
#(
  parameter int ADDR_W   = 40,
  parameter int MB_SHIFT = 20,
  localparam int SIZE_W  = ADDR_W - MB_SHIFT,
  localparam int HI_W    = ADDR_W - 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [3:0]         cfg_addr,
  input  logic [31:0]        cfg_wdata,
  output logic [31:0]        cfg_rdata,
  input  logic [N_CAUSE-1:0] fault_set,
  input  logic [ADDR_W-1:0]  fault_addr_in,
  output logic [ADDR_W-1:0]  sec_base,
  output logic [SIZE_W-1:0]  sec_size,
  output logic [ADDR_W-1:0]  vid_base,
  output logic [SIZE_W-1:0]  vid_size,
  output logic [N_CAUSE-1:0] cause
);
  logic [ADDR_W-1:0]  fault_addr;
  logic [N_CAUSE-1:0] clr_mask;

  assign clr_mask = (cfg_we && cfg_addr == IDX_CAUSE) ? cfg_wdata[N_CAUSE-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_base <= '0;
      sec_size <= '0;
      vid_base <= '0;
      vid_size <= '0;
    end else if (cfg_we) begin
      case (cfg_addr)
        IDX_SEC_LO: sec_base[31:0]       <= cfg_wdata;
        IDX_SEC_HI: sec_base[ADDR_W-1:32] <= cfg_wdata[HI_W-1:0];
        IDX_SEC_SZ: sec_size             <= cfg_wdata[SIZE_W-1:0];
        IDX_VID_LO: vid_base[31:0]       <= cfg_wdata;
        IDX_VID_HI: vid_base[ADDR_W-1:32] <= cfg_wdata[HI_W-1:0];
        IDX_VID_SZ: vid_size             <= cfg_wdata[SIZE_W-1:0];
        default: ;
      endcase
    end
  end

  // Cause bits: a new fault wins over a clear in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause      <= '0;
      fault_addr <= '0;
    end else begin
      cause <= (cause & ~clr_mask) | fault_set;
      if (fault_set != '0) fault_addr <= fault_addr_in;
    end
  end

  always_comb begin
    case (cfg_addr)
      IDX_SEC_LO:  cfg_rdata = sec_base[31:0];
      IDX_SEC_HI:  cfg_rdata = {{(32-HI_W){1'b0}}, sec_base[ADDR_W-1:32]};
      IDX_SEC_SZ:  cfg_rdata = {{(32-SIZE_W){1'b0}}, sec_size};
      IDX_VID_LO:  cfg_rdata = vid_base[31:0];
      IDX_VID_HI:  cfg_rdata = {{(32-HI_W){1'b0}}, vid_base[ADDR_W-1:32]};
      IDX_VID_SZ:  cfg_rdata = {{(32-SIZE_W){1'b0}}, vid_size};
      IDX_CAUSE:   cfg_rdata = {{(32-N_CAUSE){1'b0}}, cause};
      IDX_FADDR_L: cfg_rdata = fault_addr[31:0];
      IDX_FADDR_H: cfg_rdata = {{(32-HI_W){1'b0}}, fault_addr[ADDR_W-1:32]};
      default:     cfg_rdata = '0;
    endcase
  end

  for (genvar i = 0; i < N_CAUSE; i++) begin : g_cause_chk
    // R8: a set bit survives unless a 1 is written to it.
    p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cause[i] && !clr_mask[i]) |=> cause[i]);
    // R8: writing 1 clears the bit when no fault arrives in the same cycle.
    p_w1c_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_mask[i] && !fault_set[i]) |=> !cause[i]);
  end
endmodule

// File: rtl/carveout_filter.sv
module carveout_filter
  import carveout_pkg::*;
#(
  parameter int ADDR_W   = 40,
  parameter int MB_SHIFT = 20,
  localparam int SIZE_W  = ADDR_W - MB_SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [3:0]        cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_secure,
  input  logic              req_cpu,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_fault,
  output logic              fault_irq
);
  logic [ADDR_W-1:0]  sec_base, vid_base;
  logic [SIZE_W-1:0]  sec_size, vid_size;
  logic [N_CAUSE-1:0] cause, fault_set;
  logic               in_sec, in_vid, sec_viol, vid_viol, accept;

  carveout_regs #(.ADDR_W(ADDR_W), .MB_SHIFT(MB_SHIFT)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .fault_set(fault_set), .fault_addr_in(req_addr),
    .sec_base(sec_base), .sec_size(sec_size),
    .vid_base(vid_base), .vid_size(vid_size),
    .cause(cause)
  );

  carveout_window #(.ADDR_W(ADDR_W), .MB_SHIFT(MB_SHIFT)) u_sec_win (
    .base(sec_base), .size_mb(sec_size), .addr(req_addr), .hit(in_sec)
  );

  carveout_window #(.ADDR_W(ADDR_W), .MB_SHIFT(MB_SHIFT)) u_vid_win (
    .base(vid_base), .size_mb(vid_size), .addr(req_addr), .hit(in_vid)
  );

  // The secure window decides alone wherever it matches.
  assign sec_viol  = in_sec && !req_secure;
  assign vid_viol  = !in_sec && in_vid && req_cpu;
  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  always_comb begin
    fault_set            = '0;
    fault_set[CAUSE_SEC] = accept && sec_viol;
    fault_set[CAUSE_VID] = accept && vid_viol;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_fault <= sec_viol || vid_viol;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  assign fault_irq = |cause;

  // R2: no new request is taken while a verdict is stalled.
  p_no_accept_stall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);
  // R2: a stalled verdict stays put.
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_fault)));
  // R2: every acceptance yields a verdict on the next cycle.
  p_verdict_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);
endmodule

// File: tb/carveout_filter_test.sv
module carveout_filter_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [39:0] req_addr = '0;
  logic        req_secure = 1'b0;
  logic        req_cpu = 1'b0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic        rsp_fault;
  logic        fault_irq;

  int compared = 0;
  int mismatched = 0;
  bit exp_q[$];
  string tag_q[$];
  logic [1:0]  exp_cause = 2'b00;
  logic [39:0] exp_faddr = '0;

  always #5 clk = ~clk;

  carveout_filter uut (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_secure(req_secure), .req_cpu(req_cpu),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_fault(rsp_fault),
    .fault_irq(fault_irq)
  );

  task automatic check(input string tag, input logic [39:0] got, input logic [39:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // Monitor: pops the expected verdict at each handshake.
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) begin
        compared++;
        mismatched++;
        $display("FAIL R2: got unexpected verdict %0d expected none", rsp_fault);
      end else begin
        string t;
        bit e;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, {39'd0, rsp_fault}, {39'd0, e});
      end
    end
  end

  // Driver: cause 0 = grant, 1 = secure fault, 2 = media fault.
  task automatic send(input logic [39:0] a, input bit sec, input bit cpu,
                      input logic [1:0] cause, input string tag);
    @(posedge clk); #1;
    req_valid = 1'b1; req_addr = a; req_secure = sec; req_cpu = cpu;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    exp_q.push_back(cause != 2'b00);
    tag_q.push_back(tag);
    exp_cause = exp_cause | cause;
    if (cause != 2'b00) exp_faddr = a;
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [3:0] idx, input logic [31:0] d);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_addr = idx; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 1'b0;
    if (idx == 4'd6) exp_cause = exp_cause & ~d[1:0];
  endtask

  task automatic rd(input logic [3:0] idx, input logic [31:0] exp, input string tag);
    cfg_addr = idx;
    #1;
    check(tag, {8'd0, cfg_rdata}, {8'd0, exp});
  endtask

  task automatic chk_status(input string tag);
    rd(4'd6, {30'd0, exp_cause}, tag);
    check(tag, {39'd0, fault_irq}, {39'd0, |exp_cause});
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    mismatched++;
    compared++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1: reset state
    rd(4'd2, 32'd0, "R1 sec size");
    rd(4'd3, 32'd0, "R1 media base lo");
    check("R1 rsp_valid", {39'd0, rsp_valid}, 40'd0);
    chk_status("R1 cause");
    send(40'h00_0000_0000, 1'b0, 1'b1, 2'd0, "R1 windows off grant");
    drain();

    // R10: programming and readback
    wr(4'd0, 32'h0000_0000);
    wr(4'd1, 32'hFFFF_FF01);
    rd(4'd1, 32'h0000_0001, "R10 sec hi masked");
    wr(4'd2, 32'hFFF0_0002);
    rd(4'd2, 32'h0000_0002, "R10 sec size masked");
    wr(4'd3, 32'h0010_0000);
    wr(4'd4, 32'h0000_0001);
    wr(4'd5, 32'h0000_0004);
    rd(4'd3, 32'h0010_0000, "R10 media lo");
    rd(4'd5, 32'h0000_0004, "R10 media size");

    // R3 / R6: secure window bounds 0x1_0000_0000 .. 0x1_0020_0000
    send(40'h01_0000_0000, 1'b0, 1'b0, 2'd1, "R3 R6 base ns fault");
    send(40'h01_0000_0000, 1'b1, 1'b1, 2'd0, "R3 base secure grant");
    send(40'h00_FFFF_FFFF, 1'b0, 1'b1, 2'd0, "R6 base-1 miss");
    send(40'h01_001F_FFFF, 1'b0, 1'b0, 2'd1, "R6 end-1 hit");
    send(40'h01_0020_0000, 1'b0, 1'b0, 2'd0, "R6 end miss");
    drain();
    chk_status("R8 cause after secure faults");
    rd(4'd7, 32'h001F_FFFF, "R9 fault addr lo");
    rd(4'd8, 32'h0000_0001, "R9 fault addr hi");
    wr(4'd6, 32'h0000_0000);
    chk_status("R8 write 0 keeps");
    wr(4'd6, 32'h0000_0001);
    chk_status("R8 write 1 clears");

    // R7: overlap 0x1_0010_0000 .. 0x1_001F_FFFF
    send(40'h01_0018_0000, 1'b1, 1'b1, 2'd0, "R7 secure cpu overlap grant");
    send(40'h01_0018_0000, 1'b0, 1'b1, 2'd1, "R7 ns cpu overlap secure only");
    drain();
    chk_status("R7 only secure bit");
    wr(4'd6, 32'h0000_0003);

    // R4: media window 0x1_0010_0000 .. 0x1_0050_0000
    send(40'h01_004F_FFFF, 1'b1, 1'b1, 2'd2, "R4 cpu secure fault");
    send(40'h01_0050_0000, 1'b0, 1'b1, 2'd0, "R4 R6 media end miss");
    send(40'h01_0030_0000, 1'b0, 1'b0, 2'd0, "R4 non-cpu grant");
    drain();
    chk_status("R8 media bit");
    rd(4'd7, 32'h004F_FFFF, "R9 media fault addr");
    wr(4'd6, 32'h0000_0003);
    chk_status("R8 clear all");

    // R5: zero size disables
    wr(4'd5, 32'h0000_0000);
    send(40'h01_0030_0000, 1'b0, 1'b1, 2'd0, "R5 media off");
    wr(4'd2, 32'h0000_0000);
    send(40'h01_0000_0000, 1'b0, 1'b0, 2'd0, "R5 secure off");
    drain();
    chk_status("R5 no cause");

    // R6: window ending at 2^40
    wr(4'd0, 32'hFFF0_0000);
    wr(4'd1, 32'h0000_00FF);
    wr(4'd2, 32'h0000_0001);
    send(40'hFF_FFFF_FFFF, 1'b0, 1'b0, 2'd1, "R6 top byte hit");
    send(40'hFF_FFEF_FFFF, 1'b0, 1'b0, 2'd0, "R6 below top window");
    drain();
    rd(4'd8, 32'h0000_00FF, "R9 top fault addr hi");

    // R2: back-pressure
    rsp_ready = 1'b0;
    send(40'hFF_FFF0_0000, 1'b0, 1'b0, 2'd1, "R2 stalled verdict");
    @(negedge clk);
    check("R2 valid while stalled", {39'd0, rsp_valid}, 40'd1);
    check("R2 ready low while stalled", {39'd0, req_ready}, 40'd0);
    repeat (3) @(negedge clk);
    check("R2 verdict held", {39'd0, rsp_fault}, 40'd1);
    @(posedge clk); #1 rsp_ready = 1'b1;
    drain();
    check("R2 valid drops", {39'd0, rsp_valid}, 40'd0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule